// File: doc/BRIEF.md
# Three-Stage Processing Sequencer

This controller sits above three processing units that share working data and must run strictly one after another. The first unit works on fresh input, the second works on what the first produced, and the third works on what the second produced. Each unit is launched with a one-cycle kick and reports completion on its own finish line. The sequencer starts a pass when `go` is sampled high while it is idle. When the third unit finishes, it raises `chain_done` for one cycle and becomes idle again.

The controller is a Moore machine with eight states: idle, a kick state and a wait state for each unit, and a completion state. The state lives in an eight-flop one-hot register, and every output is a single state bit. Because each output comes straight from a flop, no input reaches an output through logic in the same cycle. Any state word that is zero or has more than one bit set returns to idle on the next edge.

Top module: `stage_chain_ctrl`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the sequencer returns to idle. All four outputs are low in the cycle after that edge, even if `go` is held high during reset.
- R2: If `go` is sampled high while idle, `kick_a` is high for exactly the next cycle.
- R3: After `kick_a`, the sequencer waits for unit A. `kick_b` is high for exactly one cycle, in the cycle after the first edge that samples `fin_a` high. That edge may come right after the `kick_a` cycle (zero wait).
- R4: After `kick_b`, `kick_c` is high for exactly one cycle, in the cycle after the first edge that samples `fin_b` high.
- R5: After `kick_c`, `chain_done` is high for exactly one cycle, in the cycle after the first edge that samples `fin_c` high. The sequencer is idle in the cycle that follows.
- R6: `go` has no effect while the sequencer is not idle. In that case the outputs follow R3 to R5 whatever `go` does.
- R7: A finish input has no effect except in its own unit's wait state. A finish in the same cycle as that unit's kick is also ignored.
- R8: At most one of `kick_a`, `kick_b`, `kick_c` and `chain_done` is high in any cycle.
- R9: If `go` is held high, the next `kick_a` comes exactly two cycles after `chain_done`, with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Request to run one pass over the three units |
| fin_a | input | 1 | Unit A has finished |
| fin_b | input | 1 | Unit B has finished |
| fin_c | input | 1 | Unit C has finished |
| kick_a | output | 1 | One-cycle start pulse to unit A |
| kick_b | output | 1 | One-cycle start pulse to unit B |
| kick_c | output | 1 | One-cycle start pulse to unit C |
| chain_done | output | 1 | One-cycle pulse when all three units have finished |

## Verification
The block has no parameters, so the bench builds its only configuration. Unit latencies are random, from zero wait (finish in the first wait cycle) up to about twenty cycles. Two kinds of noise are mixed in: `go` pulses during busy passes, and stray finish pulses on units that are not being waited on. Together these exercise every wait-state exit, every ignored-input case, and back-to-back passes with `go` held high.

// File: rtl/stage_chain_ctrl.sv
module stage_chain_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic fin_a,
  input  logic fin_b,
  input  logic fin_c,
  output logic kick_a,
  output logic kick_b,
  output logic kick_c,
  output logic chain_done
);
  localparam int NS  = 8;
  localparam int IDL = 0;
  localparam int KA  = 1;
  localparam int WA  = 2;
  localparam int KB  = 3;
  localparam int WB  = 4;
  localparam int KC  = 5;
  localparam int WC  = 6;
  localparam int FIN = 7;

  logic [NS-1:0] state, state_nx;
  logic          legal;

  assign legal = (state != '0) && ((state & (state - NS'(1))) == '0);

  always_comb begin
    state_nx = '0;
    if (!legal) begin
      state_nx[IDL] = 1'b1;
    end else begin
      state_nx[IDL] = (state[IDL] & ~go) | state[FIN];
      state_nx[KA]  = state[IDL] & go;
      state_nx[WA]  = state[KA] | (state[WA] & ~fin_a);
      state_nx[KB]  = state[WA] & fin_a;
      state_nx[WB]  = state[KB] | (state[WB] & ~fin_b);
      state_nx[KC]  = state[WB] & fin_b;
      state_nx[WC]  = state[KC] | (state[WC] & ~fin_c);
      state_nx[FIN] = state[WC] & fin_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= NS'(1) << IDL;
    else     state <= state_nx;
  end

  assign kick_a     = state[KA];
  assign kick_b     = state[KB];
  assign kick_c     = state[KC];
  assign chain_done = state[FIN];
endmodule

// File: rtl/stage_chain_ctrl_chk.sv
module stage_chain_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       go,
  input logic       fin_a,
  input logic       fin_b,
  input logic       fin_c,
  input logic       kick_a,
  input logic       kick_b,
  input logic       kick_c,
  input logic       chain_done,
  input logic [7:0] state
);
  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(state)); // R8
  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({kick_a, kick_b, kick_c, chain_done})); // R8
  AST_KA_FROM_GO: assert property (@(posedge clk) disable iff (rst) $rose(kick_a) |-> $past(go)); // R2
  AST_KA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) kick_a |=> !kick_a); // R2
  AST_KB_FROM_FIN: assert property (@(posedge clk) disable iff (rst) $rose(kick_b) |-> $past(fin_a)); // R3
  AST_KB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) kick_b |=> !kick_b); // R3
  AST_KC_FROM_FIN: assert property (@(posedge clk) disable iff (rst) $rose(kick_c) |-> $past(fin_b)); // R4
  AST_KC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) kick_c |=> !kick_c); // R4
  AST_DONE_FROM_FIN: assert property (@(posedge clk) disable iff (rst) $rose(chain_done) |-> $past(fin_c)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) chain_done |=> !chain_done && !kick_a); // R9
  AST_NO_SKIP_KA: assert property (@(posedge clk) disable iff (rst) kick_a |=> !kick_b); // R7
endmodule

bind stage_chain_ctrl stage_chain_ctrl_chk u_chk (.*);

// File: tb/test_stage_chain_ctrl.sv
`timescale 1ns/1ps
module test_stage_chain_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, fin_a = 1'b0, fin_b = 1'b0, fin_c = 1'b0;
  logic kick_a, kick_b, kick_c, chain_done;

  int vecs = 0;
  int bad  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stage_chain_ctrl i_stage_chain_ctrl (
    .clk(clk), .rst(rst), .go(go), .fin_a(fin_a), .fin_b(fin_b), .fin_c(fin_c),
    .kick_a(kick_a), .kick_b(kick_b), .kick_c(kick_c), .chain_done(chain_done)
  );

  int step = 0;
  int prev_step = 0;
  int wait_a = -1, wait_b = -1, wait_c = -1;
  string ctx;

  function automatic int pick_lat();
    int r = $urandom_range(0, 9);
    if (r < 4) return 0;
    if (r < 8) return $urandom_range(1, 5);
    return $urandom_range(6, 20);
  endfunction

  task automatic check_cycle();
    logic [3:0] got, exp;
    string tag;
    got = {kick_a, kick_b, kick_c, chain_done};
    exp = {step == 1, step == 3, step == 5, step == 7};
    vecs++;
    if (got != exp) begin
      bad++;
      if (ctx != "") tag = ctx;
      else if (got[3] != exp[3]) tag = "R2";
      else if (got[2] != exp[2]) tag = "R3";
      else if (got[1] != exp[1]) tag = "R4";
      else tag = "R5";
      $display("FAIL %s outputs {ka,kb,kc,done} actual %b expected %b at %0t", tag, got, exp, $time);
    end
    vecs++;
    if ($countones(got) > 1) begin
      bad++;
      $display("FAIL R8 outputs actual %b expected at most one high", got);
    end
  endtask

  task automatic run_cycles(input int n, input bit hold_go, input bit noisy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
      ctx = "";
      fin_a = 1'b0; fin_b = 1'b0; fin_c = 1'b0;
      if (wait_a >= 0) begin if (wait_a == 0) fin_a = 1'b1; wait_a--; end
      if (wait_b >= 0) begin if (wait_b == 0) fin_b = 1'b1; wait_b--; end
      if (wait_c >= 0) begin if (wait_c == 0) fin_c = 1'b1; wait_c--; end
      if (kick_a) wait_a = pick_lat();
      if (kick_b) wait_b = pick_lat();
      if (kick_c) wait_c = pick_lat();
      if (noisy && $urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 2))
          0: if (step != 2) begin fin_a = 1'b1; ctx = "R7"; end
          1: if (step != 4) begin fin_b = 1'b1; ctx = "R7"; end
          default: if (step != 6) begin fin_c = 1'b1; ctx = "R7"; end
        endcase
      end
      go = hold_go ? 1'b1 : ($urandom_range(0, 2) == 0);
      if (go && step != 0) ctx = "R6";
      if (step == 0 && prev_step == 7 && hold_go) ctx = "R9";
      @(posedge clk);
      prev_step = step;
      case (step)
        0: if (go) step = 1;
        2: if (fin_a) step = 3;
        4: if (fin_b) step = 5;
        6: if (fin_c) step = 7;
        7: step = 0;
        default: step = step + 1;
      endcase
    end
  endtask

  initial begin
    ctx = "";
    rst = 1'b1; go = 1'b1; fin_a = 1'b1; fin_b = 1'b1; fin_c = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecs++;
    if ({kick_a, kick_b, kick_c, chain_done} != 4'b0000) begin
      bad++;
      $display("FAIL R1 outputs after reset actual %b expected 0000",
               {kick_a, kick_b, kick_c, chain_done});
    end
    rst = 1'b0; go = 1'b0; fin_a = 1'b0; fin_b = 1'b0; fin_c = 1'b0;
    step = 0;
    run_cycles(400, 1'b1, 1'b0);
    run_cycles(3000, 1'b0, 1'b1);
    run_cycles(600, 1'b1, 1'b1);
    run_cycles(1500, 1'b0, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule